// File: doc/BRIEF.md
# Linked-Descriptor Serial Transfer Engine

This block runs a serial flash transaction from a linked list of descriptors that sits in system memory. The host writes a root pointer and pulses `start`. The engine reads the first descriptor as four consecutive words: control, buffer pointer, status and next pointer. It hands a command carrying lane count, direction, device, byte count and chip-select release to a serial lane shifter. It then moves that many bytes between the buffer and the shifter's byte streams, writes a status word back into the descriptor and follows the next pointer. A command, a dummy and a data descriptor chained without the release bit form one flash transaction under a single chip-select assertion.

The memory side is a word-wide request port. A request holds its address, write flag, data and byte enables until `mem_gnt`. A granted read returns one word on a later `mem_rvalid`, and only one request is outstanding at a time. The shifter side uses three valid/ready channels: the command, the transmit bytes and the receive bytes. When the engine asserts valid on the command or transmit channel, it keeps the payload unchanged until the cycle that ready is high. On the receive channel it takes a byte in every cycle where both `rx_valid` and `rx_ready` are high, and it does not need `rx_valid` to stay high between bytes. Three event outputs report progress: a per-descriptor interrupt, end of the list and a rejected descriptor. Each is a single-cycle pulse.

Top module: `desc_chain_engine`

## Requirements
- R1: After a `start` pulse in idle, the engine reads the words at root, root+4, root+8 and root+12 (root with its low two bits cleared) as control, buffer pointer, status and next pointer. A following descriptor is fetched from the next pointer with its low two bits cleared.
- R2: Control word fields pass to the command channel: bits [17:16] go to `cmd_lanes` (0 single, 1 dual, 2 quad), bit 18 to `cmd_rx` (1 = bytes flow from the device into memory), bits [21:20] to `cmd_dev` and bit 28 to `cmd_cs_release`. One command is issued per enabled descriptor, before any of its bytes.
- R3: Control bits [8:0] give the byte count. Values above 256 are treated as 256, and `cmd_len` carries the resulting count. A count of zero issues the command and moves no bytes.
- R4: In transmit direction, bytes are read from the buffer (pointer low bits ignored) in little-endian order: bits [7:0] of the first word go out first.
- R5: In receive direction, bytes are packed little-endian into words written at ascending addresses. A partial last word is written with byte enables set only for the received bytes, so the other bytes of that word are left unchanged.
- R6: After its data phase, each enabled descriptor's status word (descriptor+8) is written with bit 31 set and the moved byte count in the low bits.
- R7: When control bit 24 is set, `pkt_irq` pulses for one cycle after that descriptor's status write.
- R8: Control bit 29 marks the last descriptor. After its status write, `done_evt` pulses once and the engine returns to idle. Without bit 29, the next descriptor is fetched.
- R9: A descriptor whose control bit 31 is clear issues no command and moves no bytes. Its status word is written as 0x4000_0000, `err_evt` pulses once, and the engine goes idle with no `done_evt`.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: Command, transmit and memory request payloads stay stable while valid (or request) is high and ready (or grant) is low.
- R12: After reset the engine is idle: `busy`, `cmd_valid`, `tx_valid`, `mem_req`, `rx_ready` and all events are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking a list (accepted in idle) |
| root_addr | input | AW | Address of the first descriptor |
| busy | output | 1 | Engine is walking a list |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command to shifter valid |
| cmd_ready | input | 1 | Shifter accepts command |
| cmd_lanes | output | 2 | Lane mode |
| cmd_rx | output | 1 | Direction, 1 = receive |
| cmd_dev | output | 2 | Device select |
| cmd_cs_release | output | 1 | Release chip select after this command |
| cmd_len | output | CW | Byte count of this command |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Shifter takes transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Engine takes received byte |
| rx_data | input | 8 | Received byte |
| pkt_irq | output | 1 | Per-descriptor interrupt pulse |
| done_evt | output | 1 | List-complete pulse |
| err_evt | output | 1 | Disabled-descriptor pulse |

## Verification
Every result of this engine is tied to a handshake rather than a fixed latency, so the bench predicts the order of results, not their cycle. Commands and transmit bytes are compared at the exact cycle their valid/ready pair fires. The bench model drives grant and ready at the falling edge and looks at the handshake 1 ns later, just before the rising edge that completes it. Read data is returned one cycle after grant. Memory results, meaning status words and packed receive words, are read from the bench memory only after `busy` has dropped, which comes one cycle after the final status write is granted. Event pulses are counted on the same pre-edge sample and compared per run.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  localparam int B_LANE_LO = 16;
  localparam int B_RX      = 18;
  localparam int B_DEV_LO  = 20;
  localparam int B_IRQ     = 24;
  localparam int B_CSREL   = 28;
  localparam int B_LAST    = 29;
  localparam int B_EN      = 31;

  localparam logic [DW-1:0] STAT_DONE = 32'h8000_0000;
  localparam logic [DW-1:0] STAT_ERR  = 32'h4000_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_EVAL, S_CMD, S_TRD, S_TWAIT,
    S_TSH, S_RCOL, S_RWR, S_STAT, S_NEXT
  } dce_state_t;
endpackage

// File: rtl/dce_ctl_decode.sv
module dce_ctl_decode
  import dce_pkg::*;
#(
  parameter int MAXB = 256,
  parameter int CW   = $clog2(MAXB + 1)
) (
  input  logic [DW-1:0] ctrl,
  output logic          en,
  output logic          last,
  output logic          csrel,
  output logic          irq_en,
  output logic [1:0]    dev,
  output logic          rx,
  output logic [1:0]    lanes,
  output logic [CW-1:0] count
);
  logic [8:0] raw;
  logic       unused_bits;

  assign raw         = ctrl[8:0];
  assign en          = ctrl[B_EN];
  assign last        = ctrl[B_LAST];
  assign csrel       = ctrl[B_CSREL];
  assign irq_en      = ctrl[B_IRQ];
  assign dev         = ctrl[B_DEV_LO +: 2];
  assign rx          = ctrl[B_RX];
  assign lanes       = ctrl[B_LANE_LO +: 2];
  assign count       = ({23'b0, raw} > MAXB) ? CW'(MAXB) : CW'(raw);
  assign unused_bits = ^{ctrl[15:9], ctrl[19], ctrl[23:22], ctrl[27:25], ctrl[30]};
endmodule

// File: rtl/dce_tx_unpack.sv
module dce_tx_unpack
  import dce_pkg::*;
#(
  parameter int PCW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [DW-1:0]  word,
  input  logic [PCW-1:0] nbytes,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           empty
);
  logic [DW-1:0]  sh;
  logic [PCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= word;
      cnt <= nbytes;
    end else if (out_valid && out_ready) begin
      sh  <= sh >> 8;
      cnt <= cnt - PCW'(1);
    end
  end

  assign out_valid = (cnt != '0);
  assign out_data  = sh[7:0];
  assign empty     = (cnt == '0);
endmodule

// File: rtl/dce_rx_pack.sv
module dce_rx_pack
  import dce_pkg::*;
#(
  parameter int PCW = $clog2(NB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           in_fire,
  input  logic [7:0]     in_byte,
  output logic [DW-1:0]  word,
  output logic [NB-1:0]  be,
  output logic [PCW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (in_fire)
      cnt <= cnt + PCW'(1);
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        word[g*8 +: 8] <= '0;
        be[g]          <= 1'b0;
      end else if (in_fire && cnt == PCW'(g)) begin
        word[g*8 +: 8] <= in_byte;
        be[g]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
  import dce_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MAXB = 256,
  parameter int CW   = $clog2(MAXB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] root_addr,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_lanes,
  output logic          cmd_rx,
  output logic [1:0]    cmd_dev,
  output logic          cmd_cs_release,
  output logic [CW-1:0] cmd_len,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          pkt_irq,
  output logic          done_evt,
  output logic          err_evt
);
  localparam int PCW = $clog2(NB + 1);
  localparam logic [AW-1:0] AMASK = ~AW'(NB - 1);

  dce_state_t    state;
  logic [AW-1:0] desc_base, buf_ptr, w_buf, w_next;
  logic [DW-1:0] w_ctrl;
  logic [1:0]    widx;
  logic [CW-1:0] remain, moved, nb_ext;
  logic          err_flag;

  logic          d_en, d_last, d_csrel, d_irq, d_rx;
  logic [1:0]    d_dev, d_lanes;
  logic [CW-1:0] d_count;

  logic          tx_load, tx_empty;
  logic          rx_fire, pk_clr;
  logic [DW-1:0] pk_word;
  logic [NB-1:0] pk_be;
  logic [PCW-1:0] pk_cnt;
  logic [DW-1:0] stat_word;

  dce_ctl_decode #(.MAXB(MAXB), .CW(CW)) u_dec (
    .ctrl(w_ctrl), .en(d_en), .last(d_last), .csrel(d_csrel), .irq_en(d_irq),
    .dev(d_dev), .rx(d_rx), .lanes(d_lanes), .count(d_count)
  );

  assign nb_ext  = (remain >= CW'(NB)) ? CW'(NB) : remain;
  assign tx_load = (state == S_TWAIT) && mem_rvalid;

  dce_tx_unpack #(.PCW(PCW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .word(mem_rdata),
    .nbytes(PCW'(nb_ext)), .out_valid(tx_valid), .out_ready(tx_ready),
    .out_data(tx_data), .empty(tx_empty)
  );

  assign rx_ready = (state == S_RCOL);
  assign rx_fire  = rx_ready && rx_valid;
  assign pk_clr   = (state == S_RWR) && mem_gnt;

  dce_rx_pack #(.PCW(PCW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(pk_clr), .in_fire(rx_fire),
    .in_byte(rx_data), .word(pk_word), .be(pk_be), .cnt(pk_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      desc_base <= '0;
      buf_ptr   <= '0;
      w_buf     <= '0;
      w_next    <= '0;
      w_ctrl    <= '0;
      widx      <= '0;
      remain    <= '0;
      moved     <= '0;
      err_flag  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          desc_base <= root_addr & AMASK;
          widx      <= '0;
          err_flag  <= 1'b0;
          state     <= S_FREQ;
        end
        S_FREQ: if (mem_gnt) state <= S_FWAIT;
        S_FWAIT: if (mem_rvalid) begin
          case (widx)
            2'd0:    w_ctrl <= mem_rdata;
            2'd1:    w_buf  <= mem_rdata[AW-1:0];
            2'd3:    w_next <= mem_rdata[AW-1:0];
            default: ;
          endcase
          if (widx == 2'd3) state <= S_EVAL;
          else begin
            widx  <= widx + 2'd1;
            state <= S_FREQ;
          end
        end
        S_EVAL: if (!d_en) begin
          err_flag <= 1'b1;
          state    <= S_STAT;
        end else begin
          remain  <= d_count;
          moved   <= '0;
          buf_ptr <= w_buf & AMASK;
          state   <= S_CMD;
        end
        S_CMD: if (cmd_ready)
          state <= (remain == '0) ? S_STAT : (d_rx ? S_RCOL : S_TRD);
        S_TRD: if (mem_gnt) state <= S_TWAIT;
        S_TWAIT: if (mem_rvalid) begin
          remain  <= remain - nb_ext;
          moved   <= moved + nb_ext;
          buf_ptr <= buf_ptr + AW'(NB);
          state   <= S_TSH;
        end
        S_TSH: if (tx_empty) state <= (remain == '0) ? S_STAT : S_TRD;
        S_RCOL: if (rx_valid) begin
          remain <= remain - CW'(1);
          moved  <= moved + CW'(1);
          if (remain == CW'(1) || pk_cnt == PCW'(NB - 1)) state <= S_RWR;
        end
        S_RWR: if (mem_gnt) begin
          buf_ptr <= buf_ptr + AW'(NB);
          state   <= (remain == '0) ? S_STAT : S_RCOL;
        end
        S_STAT: if (mem_gnt) state <= S_NEXT;
        S_NEXT: if (err_flag || d_last) state <= S_IDLE;
        else begin
          desc_base <= w_next & AMASK;
          widx      <= '0;
          state     <= S_FREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign stat_word = err_flag ? STAT_ERR : (STAT_DONE | DW'(moved));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '1;
    case (state)
      S_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = desc_base + AW'(widx) * AW'(NB);
      end
      S_TRD: begin
        mem_req  = 1'b1;
        mem_addr = buf_ptr;
      end
      S_RWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_ptr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      S_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_base + AW'(2 * NB);
        mem_wdata = stat_word;
      end
      default: ;
    endcase
  end

  assign busy           = (state != S_IDLE);
  assign cmd_valid      = (state == S_CMD);
  assign cmd_lanes      = d_lanes;
  assign cmd_rx         = d_rx;
  assign cmd_dev        = d_dev;
  assign cmd_cs_release = d_csrel;
  assign cmd_len        = remain;
  assign pkt_irq        = (state == S_NEXT) && !err_flag && d_irq;
  assign done_evt       = (state == S_NEXT) && !err_flag && d_last;
  assign err_evt        = (state == S_NEXT) && err_flag;
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
  parameter int AW = 32,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [3:0]    mem_be,
  input logic          mem_gnt,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_lanes,
  input logic          cmd_rx,
  input logic [1:0]    cmd_dev,
  input logic          cmd_cs_release,
  input logic [CW-1:0] cmd_len,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_ready,
  input logic          pkt_irq,
  input logic          done_evt,
  input logic          err_evt
);
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_be));

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_lanes) && $stable(cmd_rx)
      && $stable(cmd_dev) && $stable(cmd_cs_release) && $stable(cmd_len));

  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_irq |=> !pkt_irq);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt && !busy);

  assert_err_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> !done_evt && !pkt_irq);

  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !busy);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !tx_valid && !mem_req && !rx_ready);
endmodule

bind desc_chain_engine dce_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lanes(cmd_lanes),
  .cmd_rx(cmd_rx), .cmd_dev(cmd_dev), .cmd_cs_release(cmd_cs_release),
  .cmd_len(cmd_len), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .pkt_irq(pkt_irq), .done_evt(done_evt), .err_evt(err_evt)
);

// File: tb/sim_desc_chain_engine.sv
`timescale 1ns/1ps
module sim_desc_chain_engine;
  localparam int AW = 32;
  localparam int CW = 9;

  logic clk = 0;
  always #2 clk = ~clk;

  logic          rst_n, start, busy;
  logic [AW-1:0] root_addr;
  logic          mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_be;
  logic          cmd_valid, cmd_ready, cmd_rx, cmd_cs_release;
  logic [1:0]    cmd_lanes, cmd_dev;
  logic [CW-1:0] cmd_len;
  logic          tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]    tx_data, rx_data;
  logic          pkt_irq, done_evt, err_evt;

  desc_chain_engine #(.AW(AW)) u0 (.*);

  logic [31:0] mem [0:1023];
  logic [14:0] exp_cmd[$];
  logic [7:0]  exp_tx[$];
  logic [7:0]  rxq[$];
  int vectors = 0, fails = 0;
  int n_irq = 0, n_done = 0, n_err = 0, cyc = 0, gnt_mode = 0;
  logic        rd_pend = 0;
  logic [31:0] rd_word = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input bit last, input bit cs,
      input bit irq, input logic [1:0] dev, input bit rx, input logic [1:0] lanes,
      input logic [8:0] cnt);
    return {en, 1'b0, last, cs, 3'b0, irq, 2'b0, dev, 1'b0, rx, lanes, 7'b0, cnt};
  endfunction

  function automatic logic [14:0] item(input logic [1:0] lanes, input bit rx,
      input logic [1:0] dev, input bit cs, input logic [8:0] len);
    return {lanes, rx, dev, cs, len};
  endfunction

  task automatic put_desc(input int base, input logic [31:0] c, input int bufp, input int nxt);
    mem[base >> 2]       = c;
    mem[(base >> 2) + 1] = bufp;
    mem[(base >> 2) + 2] = 32'hDEAD_BEEF;
    mem[(base >> 2) + 3] = nxt;
  endtask

  task automatic set_byte(input int a, input logic [7:0] b);
    mem[a >> 2][(a & 3) * 8 +: 8] = b;
  endtask

  // Bench model: memory, shifter and scoreboard monitor
  initial begin
    mem_gnt = 0; mem_rvalid = 0; mem_rdata = 0; cmd_ready = 0; tx_ready = 0;
    rx_valid = 0; rx_data = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_gnt    = (gnt_mode == 0) ? 1'b1 : (cyc % 3 != 0);
      mem_rvalid = rd_pend;
      mem_rdata  = rd_word;
      rd_pend    = 0;
      cmd_ready  = (cyc % 2 == 0);
      tx_ready   = (cyc % 5 != 2);
      rx_valid   = (rxq.size() > 0) && (cyc % 4 != 1);
      rx_data    = (rxq.size() > 0) ? rxq[0] : 8'h00;
      #1;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
        end else begin
          rd_pend = 1;
          rd_word = mem[mem_addr[11:2]];
        end
      end
      if (cmd_valid && cmd_ready) begin
        if (exp_cmd.size() == 0) chk("R2 unexpected command", 1, 0);
        else chk("R2/R3 command fields", 32'(item(cmd_lanes, cmd_rx, cmd_dev,
                 cmd_cs_release, cmd_len)), 32'(exp_cmd.pop_front()));
      end
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk("R4 unexpected tx byte", 1, 0);
        else chk("R4 tx byte", 32'(tx_data), 32'(exp_tx.pop_front()));
      end
      if (rx_valid && rx_ready) void'(rxq.pop_front());
      if (pkt_irq)  n_irq++;
      if (done_evt) n_done++;
      if (err_evt)  n_err++;
    end
  end

  task automatic run(input int root, input bit poke);
    @(negedge clk); start = 1; root_addr = root;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; root_addr = 32'h500;   // R10: must be ignored
      @(negedge clk); start = 0;
    end
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
    chk("R1 command queue drained", exp_cmd.size(), 0);
    chk("R4 tx queue drained", exp_tx.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; vectors++;
    $display("FAIL watchdog: actual hung expected idle");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    rst_n = 0; start = 0; root_addr = 0;
    repeat (4) @(negedge clk);
    #1;
    // R12 reset state
    chk("R12 idle after reset", {busy, cmd_valid, tx_valid, mem_req, rx_ready,
        pkt_irq, done_evt, err_evt}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Test A: command + dummy + receive data, one transaction (R1 R2 R5 R6 R7 R8 R10)
    put_desc(32'h100, mk_ctrl(1,0,0,0,2'd0,0,2'd2,9'd5), 32'h200, 32'h111);
    put_desc(32'h110, mk_ctrl(1,0,0,0,2'd0,0,2'd2,9'd2), 32'h210, 32'h120);
    put_desc(32'h120, mk_ctrl(1,1,1,1,2'd0,1,2'd2,9'd7), 32'h300, 0);
    mem[32'h200 >> 2] = 32'h3412_000B; mem[(32'h200 >> 2) + 1] = 32'h0000_0000;
    mem[32'h210 >> 2] = 32'h0000_A55A;
    mem[32'h300 >> 2] = 32'hAAAA_AAAA; mem[(32'h300 >> 2) + 1] = 32'hAAAA_AAAA;
    exp_cmd.push_back(item(2'd2,0,2'd0,0,9'd5));
    exp_cmd.push_back(item(2'd2,0,2'd0,0,9'd2));
    exp_cmd.push_back(item(2'd2,1,2'd0,1,9'd7));
    foreach (exp_tx[i]) ;
    exp_tx.push_back(8'h0B); exp_tx.push_back(8'h00); exp_tx.push_back(8'h12);
    exp_tx.push_back(8'h34); exp_tx.push_back(8'h00);
    exp_tx.push_back(8'h5A); exp_tx.push_back(8'hA5);
    for (int i = 0; i < 7; i++) rxq.push_back(8'h51 + 8'(i));
    run(32'h100, 1);
    chk("R5 rx full word", mem[32'h300 >> 2], 32'h5453_5251);
    chk("R5 rx partial word keeps byte 3", mem[(32'h300 >> 2) + 1], 32'hAA57_5655);
    chk("R6 status desc0", mem[(32'h100 >> 2) + 2], 32'h8000_0005);
    chk("R6 status desc1", mem[(32'h110 >> 2) + 2], 32'h8000_0002);
    chk("R6 status desc2", mem[(32'h120 >> 2) + 2], 32'h8000_0007);
    chk("R7 irq count", n_irq, 1);
    chk("R8 done count", n_done, 1);
    chk("R10 start while busy ignored", n_err, 0);

    // Test B: count above limit, transmit, misaligned buffer (R3 R4 R11)
    gnt_mode = 1;
    put_desc(32'h400, mk_ctrl(1,1,1,1,2'd2,0,2'd1,9'd300), 32'h603, 0);
    for (int i = 0; i < 256; i++) begin
      set_byte(32'h600 + i, 8'((i * 7 + 3) & 8'hFF));
      exp_tx.push_back(8'((i * 7 + 3) & 8'hFF));
    end
    exp_cmd.push_back(item(2'd1,0,2'd2,1,9'd256));
    run(32'h400, 0);
    chk("R3 saturated count status", mem[(32'h400 >> 2) + 2], 32'h8000_0100);
    chk("R7 irq count", n_irq, 2);
    chk("R8 done count", n_done, 2);

    // Test C: enabled then disabled descriptor (R9)
    put_desc(32'h700, mk_ctrl(1,0,0,0,2'd1,0,2'd0,9'd1), 32'h7A0, 32'h710);
    put_desc(32'h710, mk_ctrl(0,1,1,1,2'd0,0,2'd0,9'd3), 32'h7A0, 0);
    mem[32'h7A0 >> 2] = 32'h0000_00C3;
    exp_cmd.push_back(item(2'd0,0,2'd1,0,9'd1));
    exp_tx.push_back(8'hC3);
    run(32'h700, 0);
    chk("R9 status of enabled desc", mem[(32'h700 >> 2) + 2], 32'h8000_0001);
    chk("R9 error status", mem[(32'h710 >> 2) + 2], 32'h4000_0000);
    chk("R9 err count", n_err, 1);
    chk("R9 no done", n_done, 2);
    chk("R9 no irq", n_irq, 2);

    // Test D: zero-length receive (R3)
    gnt_mode = 0;
    put_desc(32'h720, mk_ctrl(1,1,1,0,2'd3,1,2'd0,9'd0), 32'h780, 0);
    mem[32'h780 >> 2] = 32'h1234_5678;
    exp_cmd.push_back(item(2'd0,1,2'd3,1,9'd0));
    run(32'h720, 0);
    chk("R3 zero length status", mem[(32'h720 >> 2) + 2], 32'h8000_0000);
    chk("R3 zero length no write", mem[32'h780 >> 2], 32'h1234_5678);
    chk("R8 done count", n_done, 3);

    // Test E: exact one-word receive (R5)
    put_desc(32'h740, mk_ctrl(1,1,1,0,2'd0,1,2'd1,9'd4), 32'h7C0, 0);
    mem[32'h7C0 >> 2] = 32'hFFFF_FFFF; mem[(32'h7C0 >> 2) + 1] = 32'hFFFF_FFFF;
    exp_cmd.push_back(item(2'd1,1,2'd0,1,9'd4));
    for (int i = 1; i <= 4; i++) rxq.push_back(8'(i));
    run(32'h740, 0);
    chk("R5 full word rx", mem[32'h7C0 >> 2], 32'h0403_0201);
    chk("R5 next word untouched", mem[(32'h7C0 >> 2) + 1], 32'hFFFF_FFFF);
    chk("R6 status one word", mem[(32'h740 >> 2) + 2], 32'h8000_0004);
    chk("R12 idle at end", {busy, cmd_valid, tx_valid, mem_req}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule